// File: doc/BRIEF.md
# DMA Burst Bandwidth Limiter

This block throttles one DMA channel that runs in rate-limited auto-request mode so that it cannot hold the shared bus for more than a programmed share of the time. Time is cut into fixed windows counted in DMA clock cycles. Inside each window the block counts the cycles in which the bus is busy for the channel. Once that count reaches the window's budget, the block withdraws its request permit until the next window begins.

Two 2-bit global control fields set the behaviour. The burst-time code picks the window length. The bandwidth code picks the share, which halves with each step. A new setting is taken only at a window boundary, so a window never changes length or budget partway through. Channels in full-speed auto-request mode or in either externally requested mode are never throttled.

Top module: `dma_bw_limiter`

## Requirements
- R1: After reset is released, `req_permit` is high, and the first window uses burst code 00 and share code 00 (16 cycles, budget 8) whatever the control inputs are.
- R2: The window length is 16 << `burst_code`: code 00 gives 16 cycles, 01 gives 32, 10 gives 64 and 11 gives 128. The window counter runs freely and wraps at that length.
- R3: The busy-cycle budget of a window is its length >> (`share_code` + 1): share 00 is 50 %, 01 is 25 %, 10 is 12.5 % and 11 is 6.25 % of the window.
- R4: With `req_mode` = 00 (rate-limited auto request), `req_permit` falls in the cycle after the busy cycle that brings the count to the budget and stays low until the window ends. Busy cycles while the budget is used up are not counted.
- R5: The busy count clears at each wrap, so `req_permit` is high in the first cycle of every window.
- R6: With `req_mode` 01 (full-speed auto), 10 (external) or 11 (auto first, external after), `req_permit` is high in every cycle, following a mode change in the same cycle.
- R7: `burst_code` and `share_code` are sampled only in the last cycle of a window and govern the whole next window. A change in the middle of a window has no effect on the current window.
- R8: Cycles with `bus_busy` low use up no budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DMA clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| burst_code | input | 2 | Global window-length code |
| share_code | input | 2 | Global bandwidth-share code |
| req_mode | input | 2 | Request-generation mode of the channel (00 = rate-limited auto) |
| bus_busy | input | 1 | The channel holds the bus in this cycle |
| req_permit | output | 1 | The channel may raise an auto request |

## Verification
`req_permit` is a combinational function of `req_mode` and of registered window state. A mode change therefore shows in the same cycle, and a busy cycle that exhausts the budget lowers the permit one clock edge later. A new code pair first shows in the cycle after the edge that ends the current window. The bench drives inputs on the falling edge, samples `req_permit` 1 ns later, and advances its own model of window position, active codes and busy count on each rising edge, so every comparison sees exactly the state that those register delays produce. Directed sweeps measure the permitted cycles per window and the spacing of permit rises for all 16 code pairs with the bus held busy.

// File: rtl/dma_bw_pkg.sv
package dma_bw_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    REQ_RATE_AUTO  = 2'b00,
    REQ_FULL_AUTO  = 2'b01,
    REQ_EXTERNAL   = 2'b10,
    REQ_FIRST_AUTO = 2'b11
  } req_mode_e;

  typedef struct packed {
    logic [CODE_W-1:0] burst;
    logic [CODE_W-1:0] share;
  } bw_cfg_t;

endpackage

// File: rtl/dma_bw_rst_sync.sv
module dma_bw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/dma_bw_window.sv
module dma_bw_window
  import dma_bw_pkg::*;
#(
  parameter int BASE_LOG2 = 4,
  parameter int CNT_W     = 7
) (
  input  logic    clk,
  input  logic    rst_n,
  input  bw_cfg_t cfg_in,
  output bw_cfg_t cfg_act,
  output logic    win_last
);

  logic [CNT_W-1:0] win_q;
  logic [CNT_W-1:0] win_d;
  logic [CNT_W-1:0] len_m1;
  bw_cfg_t          cfg_q;
  bw_cfg_t          cfg_d;
  logic             cfg_en;
  logic             last_c;

  // Window length minus one for the active burst code
  always_comb begin
    len_m1 = CNT_W'((32'd1 << (BASE_LOG2 + int'(cfg_q.burst))) - 32'd1);
    last_c = (win_q == len_m1);
    win_d  = last_c ? '0 : win_q + CNT_W'(1);
    cfg_en = last_c;
    cfg_d  = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cfg_q <= '0;
    end else begin
      win_q <= win_d;
      if (cfg_en) begin
        cfg_q <= cfg_d;
      end
    end
  end

  assign cfg_act  = cfg_q;
  assign win_last = last_c;

endmodule

// File: rtl/dma_bw_occupancy.sv
module dma_bw_occupancy
  import dma_bw_pkg::*;
#(
  parameter int BASE_LOG2 = 4,
  parameter int CNT_W     = 7
) (
  input  logic    clk,
  input  logic    rst_n,
  input  bw_cfg_t cfg_act,
  input  logic    win_last,
  input  logic    bus_busy,
  output logic    under_budget
);

  logic [CNT_W-1:0] busy_q;
  logic [CNT_W-1:0] busy_d;
  logic [CNT_W-1:0] budget;
  logic             busy_en;
  logic             under_c;

  always_comb begin
    budget  = CNT_W'((32'd1 << (BASE_LOG2 + int'(cfg_act.burst)))
                     >> (int'(cfg_act.share) + 1));
    under_c = (busy_q < budget);
    busy_en = win_last | (bus_busy & under_c);
    busy_d  = win_last ? '0 : busy_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else if (busy_en) begin
      busy_q <= busy_d;
    end
  end

  assign under_budget = under_c;

endmodule

// File: rtl/dma_bw_limiter.sv
module dma_bw_limiter
  import dma_bw_pkg::*;
#(
  parameter int BASE_LOG2   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] burst_code,
  input  logic [1:0] share_code,
  input  logic [1:0] req_mode,
  input  logic       bus_busy,
  output logic       req_permit
);

  localparam int NCODES = 1 << CODE_W;
  localparam int CNT_W  = BASE_LOG2 + NCODES - 1;

  logic    rst_sync_n;
  bw_cfg_t cfg_in;
  bw_cfg_t cfg_act;
  logic    win_last;
  logic    under_budget;
  logic    throttled_mode;

  dma_bw_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  always_comb begin
    cfg_in.burst = burst_code;
    cfg_in.share = share_code;
  end

  dma_bw_window #(
    .BASE_LOG2 (BASE_LOG2),
    .CNT_W     (CNT_W)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_in   (cfg_in),
    .cfg_act  (cfg_act),
    .win_last (win_last)
  );

  dma_bw_occupancy #(
    .BASE_LOG2 (BASE_LOG2),
    .CNT_W     (CNT_W)
  ) u_occupancy (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .cfg_act      (cfg_act),
    .win_last     (win_last),
    .bus_busy     (bus_busy),
    .under_budget (under_budget)
  );

  always_comb begin
    throttled_mode = (req_mode_e'(req_mode) == REQ_RATE_AUTO);
    req_permit     = !throttled_mode || under_budget;
  end

endmodule

// File: rtl/dma_bw_limiter_chk.sv
module dma_bw_limiter_chk
  import dma_bw_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input bw_cfg_t    cfg_in,
  input bw_cfg_t    cfg_act,
  input logic       win_last,
  input logic       under_budget,
  input logic       bus_busy,
  input logic [1:0] req_mode,
  input logic       req_permit
);

  // R5: a wrap restores the budget
  a_r5_refill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    win_last |=> under_budget);

  // R7: active codes hold inside a window
  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !win_last |=> $stable(cfg_act));

  // R7: codes present at the boundary become active
  a_r7_cfg_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    win_last |=> (cfg_act == $past(cfg_in)));

  // R4: once spent, the budget stays spent until the wrap
  a_r4_stays_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!under_budget && !win_last) |=> !under_budget);

  // R6: non-throttled modes always permit
  a_r6_free_modes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_mode != 2'b00) |-> req_permit);

  // R8: an idle cycle leaves the budget state unchanged
  a_r8_idle_keeps: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_busy && !win_last) |=> $stable(under_budget));

endmodule

bind dma_bw_limiter dma_bw_limiter_chk u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cfg_in       (cfg_in),
  .cfg_act      (cfg_act),
  .win_last     (win_last),
  .under_budget (under_budget),
  .bus_busy     (bus_busy),
  .req_mode     (req_mode),
  .req_permit   (req_permit)
);

// File: tb/dma_bw_limiter_tb.sv
`timescale 1ns/1ps
module dma_bw_limiter_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] burst_code;
  logic [1:0] share_code;
  logic [1:0] req_mode;
  logic       bus_busy;
  logic       req_permit;

  int checks;
  int errors;
  bit done;
  bit first_check;

  // bench model state
  int m_win;
  int m_b;
  int m_s;
  int m_busy;

  dma_bw_limiter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_code (burst_code),
    .share_code (share_code),
    .req_mode   (req_mode),
    .bus_busy   (bus_busy),
    .req_permit (req_permit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int f_len(input int b);
    return 16 << b;
  endfunction

  function automatic int f_budget(input int b, input int s);
    return f_len(b) >> (s + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // One cycle: drive at negedge, compare, advance model at posedge
  task automatic step(input logic [1:0] mode, input logic busy, output logic perm);
    bit    exp;
    string tag;
    req_mode = mode;
    bus_busy = busy;
    #1;
    perm = req_permit;
    exp  = (mode != 2'b00) || (m_busy < f_budget(m_b, m_s));
    if (first_check)                                   tag = "R1";
    else if ((int'(burst_code) != m_b) || (int'(share_code) != m_s)) tag = "R7";
    else if (mode != 2'b00)                            tag = "R6";
    else if (m_win == 0)                               tag = "R5";
    else if (!exp)                                     tag = "R4";
    else if (!busy)                                    tag = "R8";
    else                                               tag = "R3";
    first_check = 1'b0;
    check(perm == exp, tag, int'(perm), int'(exp));
    @(posedge clk);
    if (m_win == f_len(m_b) - 1) begin
      m_win  = 0;
      m_busy = 0;
      m_b    = int'(burst_code);
      m_s    = int'(share_code);
    end else begin
      m_win++;
      if (busy && (m_busy < f_budget(m_b, m_s))) m_busy++;
    end
    @(negedge clk);
  endtask

  task automatic align(input int b, input int s);
    logic p;
    burst_code = 2'(b);
    share_code = 2'(s);
    for (int k = 0; k < 400; k++) begin
      if (m_win == 0 && m_b == b && m_s == s) break;
      step(2'b00, 1'b1, p);
    end
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    logic p;
    int   hi;
    int   k;
    bit   seen_low;
    checks = 0; errors = 0; done = 1'b0; first_check = 1'b1;
    m_win = 0; m_b = 0; m_s = 0; m_busy = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b1; burst_code = 2'b11; share_code = 2'b11;
    req_mode = 2'b00; bus_busy = 1'b0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);

    // R1: first window runs with codes 00/00 although inputs say 11/11
    hi = 0;
    for (int i = 0; i < 16; i++) begin
      step(2'b00, 1'b1, p);
      if (p) hi++;
    end
    check(hi == 8, "R1", hi, 8);

    // R2, R3: all 16 code pairs with the bus held busy
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 4; s++) begin
        align(b, s);
        hi = 0;
        for (int i = 0; i < f_len(b); i++) begin
          step(2'b00, 1'b1, p);
          if (p) hi++;
        end
        check(hi == f_budget(b, s), "R3", hi, f_budget(b, s));
        k = 0; seen_low = 1'b0;
        for (int i = 0; i < 400; i++) begin
          step(2'b00, 1'b1, p);
          if (!p) seen_low = 1'b1;
          else if (seen_low) break;
          k++;
        end
        check(k == f_len(b), "R2", k, f_len(b));
      end
    end

    // R8: alternate busy and idle in a 16-cycle, budget-8 window
    align(0, 0);
    hi = 0;
    for (int i = 0; i < 16; i++) begin
      step(2'b00, (i % 2) == 0, p);
      if (p) hi++;
    end
    check(hi == 15, "R8", hi, 15);

    // R6: full-speed mode never throttled
    align(0, 3);
    hi = 0;
    for (int i = 0; i < 16; i++) begin
      step(2'b01, 1'b1, p);
      if (p) hi++;
    end
    check(hi == 16, "R6", hi, 16);

    // R7: mid-window change leaves this window at 16 cycles, budget 8
    align(0, 0);
    hi = 0;
    for (int i = 0; i < 16; i++) begin
      if (i == 3) begin burst_code = 2'b01; share_code = 2'b01; end
      step(2'b00, 1'b1, p);
      if (p) hi++;
    end
    check(hi == 8, "R7", hi, 8);
    hi = 0;
    for (int i = 0; i < 32; i++) begin
      step(2'b00, 1'b1, p);
      if (p) hi++;
    end
    check(hi == 8, "R7", hi, 8);

    // Random mix of modes, busy patterns and code changes
    for (int i = 0; i < 6000; i++) begin
      logic [1:0] md;
      if ($urandom % 40 == 0) begin
        burst_code = 2'($urandom % 4);
        share_code = 2'($urandom % 4);
      end
      md = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'b00;
      step(md, ($urandom % 3) != 0, p);
    end

    finish_run();
  end

endmodule